// File: doc/BRIEF.md
# Coarse-Vector Sharer Directory Entry

This block holds the directory record for one home memory block: a 64-bit entry made of a presence vector, a coherence state and an owner field. Nodes send read-share and write requests, each tagged with the requesting node number. A static node-count input sets the machine size. Up to 48 nodes, each presence bit stands for exactly one node. Above that, each bit covers a power-of-two group of nodes. The vector then tracks sharing only approximately: a set bit means that at least one node in its group may hold a copy.

A read request adds the requester's group to the presence vector. A write request starts an invalidation walk. The walk emits, one per handshake, the number of every node that lies in a group whose bit is set, skipping the writer. When no target remains, the block raises a done flag for one cycle. In that same cycle it commits the write: only the writer's group bit stays set, the state becomes exclusive and the owner field records the writer.

Both streams use valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a walk still has targets left. An invalidation target transfers when `inv_valid` and `inv_ready` are both high. While `inv_ready` is low, `inv_valid` stays high and `inv_node` does not change. The consumer may hold `inv_ready` low for any number of cycles.

Top module: `cvdir_entry`

## Requirements
- R1: After reset the entry is all zero (state uncached, no presence bits, owner 0), `inv_valid` and `inv_done` are low and `req_ready` is high.
- R2: The group shift k is 0 when `node_count` <= 48. Otherwise k is the smallest value with `node_count` <= 48*2^k. A node maps to presence bit (node >> k). For example, 64 nodes give groups of two and 128 nodes give groups of four.
- R3: An accepted read sets the requester's group bit and keeps all other presence bits. It sets the state to shared (01) and clears the owner field. All of this shows on `entry` in the cycle after acceptance.
- R4: After a write is accepted, the invalidation targets are exactly the nodes below `node_count` whose group bit is set, minus the writer. They are emitted in ascending order, one per transfer.
- R5: While `inv_valid` is high and `inv_ready` is low, on the next cycle `inv_valid` is still high and `inv_node` has not changed.
- R6: `inv_done` is high for exactly one cycle, when the walk has no target left, and never together with `inv_valid`. On the following cycle `entry` holds only the writer's group bit, state exclusive (10) and owner equal to the writer.
- R7: A write with no target raises `inv_done` in the first cycle after acceptance and emits no target.
- R8: `req_ready` is low while `inv_valid` is high, and high in the `inv_done` cycle. A request accepted in the `inv_done` cycle is applied on top of the committed write result.
- R9: Entry layout: bits 47:0 are presence bits and bits 49:48 are the state (00 uncached, 01 shared, 10 exclusive; 11 never appears). Bits 56:50 are the owner field and bits 63:57 are zero.
- R10: When the last group is only partly populated, nodes at or above `node_count` are never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_count | input | 8 | Number of nodes in the machine (static) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read-share |
| req_node | input | 7 | Requesting node number |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Consumer takes the target |
| inv_node | output | 7 | Node to invalidate |
| inv_done | output | 1 | Walk finished; write commits this cycle |
| entry | output | 64 | Current directory entry |

## Verification
Two things can happen in the same cycle: the end of an invalidation walk, with its entry commit, and the acceptance of the next request. To provoke this, the bench starts a write that has several targets and then holds a read request valid for the whole walk. The bench confirms that the read stays blocked while targets are still flowing and that it is taken exactly in the done cycle. It then checks that the next entry merges the committed writer group with the reader's group under the shared state, rather than building on the entry as it stood before the write.

// File: rtl/cvdir_pkg.sv
package cvdir_pkg;
  typedef enum logic [1:0] {
    ST_UNC = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10
  } dir_state_e;
endpackage

// File: rtl/cvdir_coarse.sv
module cvdir_coarse #(
  parameter int NODE_W    = 7,
  parameter int PRES_BITS = 48,
  parameter int SHIFT_W   = 3
) (
  input  logic [NODE_W:0]    node_count,
  output logic [SHIFT_W-1:0] shift
);
  logic found;
  always_comb begin
    shift = '0;
    found = 1'b0;
    for (int k = 0; k <= NODE_W; k++) begin
      if (!found && (int'(node_count) <= (PRES_BITS << k))) begin
        shift = SHIFT_W'(k);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvdir_scan.sv
module cvdir_scan #(
  parameter int NODE_W    = 7,
  parameter int PRES_BITS = 48,
  parameter int SHIFT_W   = 3
) (
  input  logic [PRES_BITS-1:0] pres,
  input  logic [SHIFT_W-1:0]   shift,
  input  logic [NODE_W:0]      node_count,
  input  logic [NODE_W-1:0]    writer,
  input  logic [NODE_W:0]      ptr,
  output logic                 hit,
  output logic [NODE_W-1:0]    hit_node
);
  localparam int NODES_MAX = 1 << NODE_W;

  logic [NODES_MAX-1:0] pres_pad;
  logic [NODES_MAX-1:0] cand;

  assign pres_pad = NODES_MAX'(pres);

  for (genvar n = 0; n < NODES_MAX; n++) begin : g_node
    logic [NODE_W-1:0] grp;
    assign grp     = NODE_W'(n) >> shift;
    assign cand[n] = ((NODE_W+1)'(n) < node_count) && pres_pad[grp] &&
                     (NODE_W'(n) != writer) && ((NODE_W+1)'(n) >= ptr);
  end

  always_comb begin
    hit      = 1'b0;
    hit_node = '0;
    for (int n = NODES_MAX - 1; n >= 0; n--) begin
      if (cand[n]) begin
        hit      = 1'b1;
        hit_node = NODE_W'(n);
      end
    end
  end
endmodule

// File: rtl/cvdir_entry.sv
module cvdir_entry #(
  parameter int NODE_W    = 7,
  parameter int PRES_BITS = 48,
  parameter int ENTRY_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NODE_W:0]     node_count,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [NODE_W-1:0]   req_node,
  output logic                inv_valid,
  input  logic                inv_ready,
  output logic [NODE_W-1:0]   inv_node,
  output logic                inv_done,
  output logic [ENTRY_W-1:0]  entry
);
  import cvdir_pkg::*;

  localparam int NODES_MAX = 1 << NODE_W;
  localparam int SHIFT_W   = $clog2(NODE_W + 1);
  localparam int STATE_LSB = PRES_BITS;
  localparam int OWNER_LSB = PRES_BITS + 2;

  logic [PRES_BITS-1:0] pres_q, pres_d, base_pres;
  dir_state_e           state_q, state_d, base_state;
  logic [NODE_W-1:0]    owner_q, owner_d, base_owner;
  logic                 walking_q, walking_d;
  logic [NODE_W-1:0]    writer_q, writer_d;
  logic [NODE_W:0]      ptr_q, ptr_d;

  logic [SHIFT_W-1:0]   shift;
  logic                 scan_hit;
  logic [NODE_W-1:0]    scan_node;
  logic                 walk_end, accept;
  logic [NODES_MAX-1:0] wr_onehot, rd_onehot;

  cvdir_coarse #(.NODE_W(NODE_W), .PRES_BITS(PRES_BITS), .SHIFT_W(SHIFT_W)) u_coarse (
    .node_count (node_count),
    .shift      (shift)
  );

  cvdir_scan #(.NODE_W(NODE_W), .PRES_BITS(PRES_BITS), .SHIFT_W(SHIFT_W)) u_scan (
    .pres       (pres_q),
    .shift      (shift),
    .node_count (node_count),
    .writer     (writer_q),
    .ptr        (ptr_q),
    .hit        (scan_hit),
    .hit_node   (scan_node)
  );

  assign walk_end  = walking_q && !scan_hit;
  assign inv_valid = walking_q && scan_hit;
  assign inv_node  = scan_node;
  assign inv_done  = walk_end;
  assign req_ready = !walking_q || walk_end;
  assign accept    = req_valid && req_ready;

  assign wr_onehot = NODES_MAX'(1) << (writer_q >> shift);
  assign rd_onehot = NODES_MAX'(1) << (req_node >> shift);

  // Committed view: the write result takes effect in the done cycle.
  always_comb begin
    if (walk_end) begin
      base_pres  = wr_onehot[PRES_BITS-1:0];
      base_state = ST_EXC;
      base_owner = writer_q;
    end else begin
      base_pres  = pres_q;
      base_state = state_q;
      base_owner = owner_q;
    end
  end

  always_comb begin
    pres_d    = base_pres;
    state_d   = base_state;
    owner_d   = base_owner;
    walking_d = walking_q && !walk_end;
    writer_d  = writer_q;
    ptr_d     = ptr_q;
    if (inv_valid && inv_ready) ptr_d = {1'b0, scan_node} + (NODE_W+1)'(1);
    if (accept) begin
      if (req_write) begin
        walking_d = 1'b1;
        writer_d  = req_node;
        ptr_d     = '0;
      end else begin
        pres_d  = base_pres | rd_onehot[PRES_BITS-1:0];
        state_d = ST_SHR;
        owner_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q    <= '0;
      state_q   <= ST_UNC;
      owner_q   <= '0;
      walking_q <= 1'b0;
      writer_q  <= '0;
      ptr_q     <= '0;
    end else begin
      pres_q    <= pres_d;
      state_q   <= state_d;
      owner_q   <= owner_d;
      walking_q <= walking_d;
      writer_q  <= writer_d;
      ptr_q     <= ptr_d;
    end
  end

  always_comb begin
    entry = '0;
    entry[PRES_BITS-1:0]        = pres_q;
    entry[STATE_LSB +: 2]       = state_q;
    entry[OWNER_LSB +: NODE_W]  = owner_q;
  end
endmodule

// File: rtl/cvdir_entry_chk.sv
module cvdir_entry_chk #(
  parameter int NODE_W    = 7,
  parameter int PRES_BITS = 48,
  parameter int ENTRY_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NODE_W:0]    node_count,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [NODE_W-1:0]  req_node,
  input logic               inv_valid,
  input logic               inv_ready,
  input logic [NODE_W-1:0]  inv_node,
  input logic               inv_done,
  input logic [ENTRY_W-1:0] entry
);
  localparam int STATE_LSB = PRES_BITS;
  localparam int OWNER_LSB = PRES_BITS + 2;
  localparam int TOP_LSB   = PRES_BITS + 2 + NODE_W;

  logic rd_accept;
  assign rd_accept = req_valid && req_ready && !req_write;

  assert_inv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_node));

  assert_done_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_valid && inv_done));

  assert_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done && !rd_accept |=> entry[STATE_LSB +: 2] == 2'b10);

  assert_walk_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> req_ready);

  assert_read_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> entry[STATE_LSB +: 2] == 2'b01 && entry[OWNER_LSB +: NODE_W] == '0);

  assert_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    entry[STATE_LSB +: 2] != 2'b11 && entry[ENTRY_W-1:TOP_LSB] == '0);

  assert_target_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> {1'b0, inv_node} < node_count);
endmodule

bind cvdir_entry cvdir_entry_chk #(
  .NODE_W(NODE_W), .PRES_BITS(PRES_BITS), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .node_count(node_count),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_node(req_node), .inv_valid(inv_valid), .inv_ready(inv_ready),
  .inv_node(inv_node), .inv_done(inv_done), .entry(entry)
);

// File: tb/cvdir_entry_test.sv
module cvdir_entry_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  node_count = 8'd32;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [6:0]  req_node = '0;
  logic        inv_valid;
  logic        inv_ready = 1'b0;
  logic [6:0]  inv_node;
  logic        inv_done;
  logic [63:0] entry;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  cvdir_entry uut (
    .clk(clk), .rst_n(rst_n), .node_count(node_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_node(req_node), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_node(inv_node), .inv_done(inv_done), .entry(entry)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] ent(logic [47:0] p, logic [1:0] s, logic [6:0] o);
    return {7'b0, o, s, p};
  endfunction

  function automatic logic [47:0] pb(int i);
    return 48'd1 << i;
  endfunction

  function automatic logic [127:0] nb(int i);
    return 128'd1 << i;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset(input logic [7:0] nc);
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; inv_ready = 1'b0; node_count = nc;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input bit wr, input logic [6:0] node);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_node = node;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Collects targets until the done cycle; returns the target set and cycle count.
  task automatic collect(input bit bp, input string req, output logic [127:0] got, output int ncyc);
    int last = -1;
    bit stall = 0;
    logic [6:0] held = '0;
    got = '0;
    ncyc = -1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      inv_ready = bp ? c[0] : 1'b1;
      #1;
      if (stall) begin
        chk(inv_valid && inv_node == held, "R5", {120'd0, inv_node}, {120'd0, held});
        stall = 0;
      end
      if (inv_valid) begin
        if (inv_ready) begin
          chk(int'(inv_node) > last, {req, " order"}, {121'd0, inv_node}, last);
          got  = got | nb(int'(inv_node));
          last = int'(inv_node);
        end else begin
          stall = 1;
          held  = inv_node;
        end
      end
      if (inv_done) begin
        ncyc = c;
        break;
      end
    end
    inv_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(8'd32);
    #1;
    chk(entry == 64'd0, "R1 entry", entry, 0);
    chk(!inv_valid && !inv_done && req_ready, "R1 flags", {inv_valid, inv_done, req_ready}, 3'b001);
  endtask

  task automatic t_exact();
    logic [127:0] got; int n;
    do_reset(8'd32);
    send(0, 7'd3); send(0, 7'd10);
    @(negedge clk);
    chk(entry == ent(pb(3) | pb(10), 2'b01, 0), "R3 exact reads", entry, ent(pb(3) | pb(10), 2'b01, 0));
    send(1, 7'd10);
    collect(0, "R4", got, n);
    chk(got == nb(3), "R4 exact targets", got, nb(3));
    @(negedge clk);
    chk(entry == ent(pb(10), 2'b10, 7'd10), "R6 exact commit", entry, ent(pb(10), 2'b10, 7'd10));
  endtask

  task automatic t_coarse2();
    logic [127:0] got; int n;
    do_reset(8'd64);
    send(0, 7'd5); send(0, 7'd40);
    @(negedge clk);
    chk(entry == ent(pb(2) | pb(20), 2'b01, 0), "R2 groups of two", entry, ent(pb(2) | pb(20), 2'b01, 0));
    send(1, 7'd4);
    collect(1, "R4", got, n);
    chk(got == (nb(5) | nb(40) | nb(41)), "R4 coarse2 targets", got, nb(5) | nb(40) | nb(41));
    @(negedge clk);
    chk(entry == ent(pb(2), 2'b10, 7'd4), "R6 coarse2 commit", entry, ent(pb(2), 2'b10, 7'd4));
  endtask

  task automatic t_coarse4();
    logic [127:0] got, exp; int n;
    do_reset(8'd128);
    send(0, 7'd127); send(0, 7'd9);
    @(negedge clk);
    chk(entry == ent(pb(31) | pb(2), 2'b01, 0), "R2 groups of four", entry, ent(pb(31) | pb(2), 2'b01, 0));
    send(1, 7'd0);
    collect(1, "R4", got, n);
    exp = '0;
    for (int i = 8; i < 12; i++) exp |= nb(i);
    for (int i = 124; i < 128; i++) exp |= nb(i);
    chk(got == exp, "R4 coarse4 targets", got, exp);
    @(negedge clk);
    chk(entry == ent(pb(0), 2'b10, 7'd0), "R6 coarse4 commit", entry, ent(pb(0), 2'b10, 7'd0));
  endtask

  task automatic t_partial();
    logic [127:0] got; int n;
    do_reset(8'd98);
    send(0, 7'd97);
    @(negedge clk);
    chk(entry == ent(pb(24), 2'b01, 0), "R2 98 nodes", entry, ent(pb(24), 2'b01, 0));
    send(1, 7'd1);
    collect(0, "R10", got, n);
    chk(got == (nb(96) | nb(97)), "R10 partial group", got, nb(96) | nb(97));
  endtask

  task automatic t_edge48();
    logic [127:0] got; int n;
    do_reset(8'd48);
    send(0, 7'd47);
    @(negedge clk);
    chk(entry == ent(pb(47), 2'b01, 0), "R2 48 nodes exact", entry, ent(pb(47), 2'b01, 0));
    send(1, 7'd0);
    collect(0, "R4", got, n);
    chk(got == nb(47), "R4 48 targets", got, nb(47));
  endtask

  task automatic t_solo();
    logic [127:0] got; int n;
    do_reset(8'd32);
    send(1, 7'd7);
    collect(0, "R7", got, n);
    chk(got == 0 && n == 0, "R7 no targets", {got[63:0], 64'(n)}, 0);
    @(negedge clk);
    chk(entry == ent(pb(7), 2'b10, 7'd7), "R6 solo commit", entry, ent(pb(7), 2'b10, 7'd7));
    send(0, 7'd2);
    @(negedge clk);
    chk(entry == ent(pb(7) | pb(2), 2'b01, 0), "R3 read after exclusive", entry, ent(pb(7) | pb(2), 2'b01, 0));
  endtask

  task automatic t_overlap();
    logic [127:0] got;
    int last = -1;
    bit blocked_ok = 1, seen_done = 0;
    do_reset(8'd64);
    send(0, 7'd20);
    send(1, 7'd3);
    req_valid = 1'b1; req_write = 1'b0; req_node = 7'd50;
    got = '0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      inv_ready = 1'b1;
      #1;
      if (inv_valid) begin
        if (req_ready) blocked_ok = 0;
        got |= nb(int'(inv_node));
      end
      if (inv_done) begin
        seen_done = 1;
        chk(req_ready, "R8 ready at done", {127'd0, req_ready}, 1);
        break;
      end
    end
    chk(blocked_ok && seen_done, "R8 blocked during walk", {blocked_ok, seen_done}, 2'b11);
    chk(got == (nb(20) | nb(21)), "R4 overlap targets", got, nb(20) | nb(21));
    @(posedge clk);
    #1;
    req_valid = 1'b0; inv_ready = 1'b0;
    @(negedge clk);
    chk(entry == ent(pb(1) | pb(25), 2'b01, 0), "R8 merged entry", entry, ent(pb(1) | pb(25), 2'b01, 0));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        summary();
      end
    end
  end

  initial begin
    t_reset();
    t_exact();
    t_coarse2();
    t_coarse4();
    t_partial();
    t_edge48();
    t_solo();
    t_overlap();
    summary();
  end
endmodule